// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This block watches a memory controller and counts what it does. It holds four counters that share one register bus. Counter 0 is fixed to count clock cycles. Counters 1 to 3 each count one event source, picked by an 8-bit select code in that counter's control word. The sources are single-cycle pulses, plus read and write transaction strobes that carry an ID. Two select codes count those transactions only when the ID passes a masked compare against a shared filter register.

Software programs a counter by writing one control word. With clear and enable both set, the counter restarts from zero. With enable low, the counter freezes and its value stays readable. When the cycle counter wraps, a sticky overflow flag is set and the interrupt output goes high. Rewriting counter 0's control word with the clear bit set drops the interrupt. The register bus accepts every request in the cycle it is presented, so it never applies back-pressure. Read data comes back exactly one cycle later, marked by a one-cycle valid pulse.

Top module: `memctl_evt_counters`

## Requirements
- R1: After reset, all counts, control words and the filter register read as 0, and both `irq` and `rd_valid` are low.
- R2: A read request (`req_valid` high, `req_write` low) is answered in the next cycle, with `rd_valid` high for that one cycle. Control word n sits at byte address 4*n. Count n reads at 0x20+4*n. The filter register is at 0x30.
- R3: Control word layout: bit 0 is the overflow flag, bit 1 is clear, bit 2 is enable and bits 31:24 are the select code. Clear always reads back as 0, and so do bits 23:3.
- R4: A control write with clear and enable set makes the count 0 at that edge. The count then rises by one on each later edge where the selected event is high. The edge of a control write never adds a count.
- R5: A control write with enable low stops the counter. Its count holds, whatever its inputs do.
- R6: Counter 0 counts every cycle while enabled. Its select field ignores writes and reads as 0.
- R7: Each select code picks one lane of `mc_evt`: 0x04 picks lane 0, 0x05 lane 1, 0x31 lane 2, 0x32 lane 3, 0x37 lane 4, 0x20 lane 5, 0x21 lane 6 and 0x30 lane 7. Code 0x00 counts cycles. Any code not listed counts nothing.
- R8: Code 0x41 counts cycles where `rd_txn_vld` is high and the read ID matches. Code 0x42 does the same for `wr_txn_vld` and the write ID. The filter register holds a compare ID in bits 15:0 and a mask in bits 31:16. An ID matches when it equals the compare ID in every bit the mask sets.
- R9: Counts wrap modulo 2^CNT_W (32 by default). A wrap from all ones to 0 sets the overflow flag. The flag stays set until a control write with clear set, and a write without clear leaves it set.
- R10: `irq` follows counter 0's overflow flag only. Overflow on counters 1 to 3 never raises it.
- R11: Reads from any other address return 0. Writes to any other address, and to the count addresses, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| mc_evt | input | 8 | Event pulse lanes |
| rd_txn_vld | input | 1 | Read transaction strobe |
| rd_txn_id | input | 16 | Read transaction ID |
| wr_txn_vld | input | 1 | Write transaction strobe |
| wr_txn_id | input | 16 | Write transaction ID |
| irq | output | 1 | Cycle counter overflow interrupt |

## Verification
At full width, the cycle counter only wraps after 2^32 cycles, so the interrupt path cannot be reached from the ports in a reasonable run. The bench builds the block with the counter width narrowed to 10 bits. It then lets the cycle counter run for exactly 1023 and then 1024 cycles after a clear, which lands on the edge where the flag sets. It also drives 1024 pulses into an event counter to show that this wrap sets the flag without raising the interrupt. It then checks that the flag survives a write without clear and falls after a write with clear.

// File: rtl/memctl_evt_pkg.sv
package memctl_evt_pkg;
  localparam int SEL_W   = 8;
  localparam int SEL_LSB = 24;
  localparam int BIT_OVF = 0;
  localparam int BIT_CLR = 1;
  localparam int BIT_EN  = 2;

  localparam logic [SEL_W-1:0] CODE_CYCLES = 8'h00;
  localparam logic [SEL_W-1:0] CODE_RD_ID  = 8'h41;
  localparam logic [SEL_W-1:0] CODE_WR_ID  = 8'h42;

  // Lane of the pulse vector picked by a select code, -1 when none.
  function automatic int lane_of(logic [SEL_W-1:0] code);
    case (code)
      8'h04:   return 0;
      8'h05:   return 1;
      8'h31:   return 2;
      8'h32:   return 3;
      8'h37:   return 4;
      8'h20:   return 5;
      8'h21:   return 6;
      8'h30:   return 7;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/memctl_evt_filter.sv
module memctl_evt_filter #(
  parameter int ID_W = 16
) (
  input  logic [2*ID_W-1:0] filt,
  input  logic              rd_txn_vld,
  input  logic [ID_W-1:0]   rd_txn_id,
  input  logic              wr_txn_vld,
  input  logic [ID_W-1:0]   wr_txn_id,
  output logic              rd_match,
  output logic              wr_match
);
  logic [ID_W-1:0] cmp_id, cmp_mask;

  assign cmp_id   = filt[ID_W-1:0];
  assign cmp_mask = filt[2*ID_W-1:ID_W];
  assign rd_match = rd_txn_vld && (((rd_txn_id ^ cmp_id) & cmp_mask) == '0);
  assign wr_match = wr_txn_vld && (((wr_txn_id ^ cmp_id) & cmp_mask) == '0);
endmodule

// File: rtl/memctl_evt_slot.sv
module memctl_evt_slot
  import memctl_evt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int EVT_W       = 8,
  parameter bit CYCLES_ONLY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_clr,
  input  logic             ctrl_en,
  input  logic [SEL_W-1:0] ctrl_sel,
  input  logic [EVT_W-1:0] evt,
  input  logic             rd_match,
  input  logic             wr_match,
  output logic [CNT_W-1:0] cnt_q,
  output logic             en_q,
  output logic             ovf_q,
  output logic [SEL_W-1:0] sel_q
);
  logic             hit;
  logic [SEL_W-1:0] sel_d;

  generate
    if (CYCLES_ONLY) begin : g_cyc
      logic sink_unused;
      assign sink_unused = ^{evt, rd_match, wr_match, ctrl_sel};
      assign hit   = 1'b1;
      assign sel_d = '0;
    end else begin : g_sel
      assign sel_d = ctrl_sel;
      always_comb begin
        hit = 1'b0;
        if (sel_q == CODE_CYCLES) hit = 1'b1;
        if (sel_q == CODE_RD_ID)  hit = rd_match;
        if (sel_q == CODE_WR_ID)  hit = wr_match;
        for (int k = 0; k < EVT_W; k++)
          if (lane_of(sel_q) == k) hit = evt[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
      sel_q <= '0;
    end else if (ctrl_wr) begin
      en_q  <= ctrl_en;
      sel_q <= sel_d;
      if (ctrl_clr) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end
    end else if (en_q && hit) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/memctl_evt_counters.sv
module memctl_evt_counters
  import memctl_evt_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int EVT_W   = 8,
  parameter int ID_W    = 16,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic [EVT_W-1:0] mc_evt,
  input  logic             rd_txn_vld,
  input  logic [ID_W-1:0]  rd_txn_id,
  input  logic             wr_txn_vld,
  input  logic [ID_W-1:0]  wr_txn_id,
  output logic             irq
);
  localparam int CTRL_BASE = 'h00;
  localparam int CNT_BASE  = 'h20;
  localparam int FILT_ADDR = 'h30;
  localparam int FILT_W    = 2 * ID_W;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel_q;
  logic [NUM_CNT-1:0]            en_q, ovf_q, ctrl_wr;
  logic [FILT_W-1:0]             filt_q;
  logic                          rd_match, wr_match, wr_req, rd_req;
  logic [DW-1:0]                 rd_mux;

  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) filt_q <= '0;
    else if (wr_req && req_addr == AW'(FILT_ADDR)) filt_q <= req_wdata[FILT_W-1:0];
  end

  memctl_evt_filter #(.ID_W(ID_W)) u_filter (
    .filt       (filt_q),
    .rd_txn_vld (rd_txn_vld),
    .rd_txn_id  (rd_txn_id),
    .wr_txn_vld (wr_txn_vld),
    .wr_txn_id  (wr_txn_id),
    .rd_match   (rd_match),
    .wr_match   (wr_match)
  );

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
      assign ctrl_wr[i] = wr_req && (req_addr == AW'(CTRL_BASE + 4 * i));
      memctl_evt_slot #(
        .CNT_W       (CNT_W),
        .EVT_W       (EVT_W),
        .CYCLES_ONLY (i == 0)
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr[i]),
        .ctrl_clr (req_wdata[BIT_CLR]),
        .ctrl_en  (req_wdata[BIT_EN]),
        .ctrl_sel (req_wdata[SEL_LSB +: SEL_W]),
        .evt      (mc_evt),
        .rd_match (rd_match),
        .wr_match (wr_match),
        .cnt_q    (cnt_q[i]),
        .en_q     (en_q[i]),
        .ovf_q    (ovf_q[i]),
        .sel_q    (sel_q[i])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (req_addr == AW'(CTRL_BASE + 4 * i)) begin
        rd_mux[SEL_LSB +: SEL_W] = sel_q[i];
        rd_mux[BIT_EN]           = en_q[i];
        rd_mux[BIT_OVF]          = ovf_q[i];
      end
      if (req_addr == AW'(CNT_BASE + 4 * i)) rd_mux = DW'(cnt_q[i]);
    end
    if (req_addr == AW'(FILT_ADDR)) rd_mux = DW'(filt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? rd_mux : '0;
    end
  end

  assign irq = ovf_q[0];
endmodule

// File: rtl/memctl_evt_checker.sv
module memctl_evt_checker #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [AW-1:0]    req_addr,
  input logic [DW-1:0]    req_wdata,
  input logic             rd_valid,
  input logic [DW-1:0]    rd_data,
  input logic             irq,
  input logic [CNT_W-1:0] cnt0,
  input logic             en0
);
  logic rdq, ctrl0_wr, clr0_wr, in_ctrl, mapped;

  assign rdq      = req_valid && !req_write;
  assign ctrl0_wr = req_valid && req_write && (req_addr == '0);
  assign clr0_wr  = ctrl0_wr && req_wdata[1];
  assign in_ctrl  = (req_addr < AW'(4 * NUM_CNT));
  assign mapped   = (req_addr[1:0] == 2'b00) &&
                    (in_ctrl || req_addr == AW'('h30) ||
                     (req_addr >= AW'('h20) && req_addr < AW'('h20 + 4 * NUM_CNT)));

  // R2
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) rdq |=> rd_valid);
  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !rdq |=> !rd_valid);
  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq && !mapped) |=> (rd_data == '0));
  // R3
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq && in_ctrl) |=> (rd_data[1] == 1'b0 && rd_data[23:3] == '0));
  // R6
  cyc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 && !ctrl0_wr) |=> (cnt0 == $past(cnt0) + 1'b1));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && !ctrl0_wr) |=> $stable(cnt0));
  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr0_wr));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (&$past(cnt0)));
endmodule

bind memctl_evt_counters memctl_evt_checker #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W),
  .AW      (AW),
  .DW      (DW)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .irq       (irq),
  .cnt0      (cnt_q[0]),
  .en0       (en_q[0])
);

// File: tb/test_memctl_evt_counters.sv
module test_memctl_evt_counters;
  localparam int CW = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [7:0]  mc_evt = '0;
  logic        rd_txn_vld = 1'b0, wr_txn_vld = 1'b0;
  logic [15:0] rd_txn_id = '0, wr_txn_id = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  memctl_evt_counters #(.CNT_W(CW)) i_memctl_evt_counters (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .mc_evt(mc_evt), .rd_txn_vld(rd_txn_vld), .rd_txn_id(rd_txn_id),
    .wr_txn_vld(wr_txn_vld), .wr_txn_id(wr_txn_id), .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [31:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(logic [31:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected rd_valid", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] codes [8];
    codes = '{8'h04, 8'h05, 8'h31, 8'h32, 8'h37, 8'h20, 8'h21, 8'h30};
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    bus_rd(32'h00, 32'h0, "R1 ctrl0");
    bus_rd(32'h20, 32'h0, "R1 count0");
    bus_rd(32'h2C, 32'h0, "R1 count3");
    bus_rd(32'h30, 32'h0, "R1 filter");

    // R6 cycle counter, select ignored; R4 start from zero
    bus_wr(32'h00, 32'hAB00_0006);
    idle(37);
    bus_wr(32'h00, 32'h0);
    bus_rd(32'h20, 32'd37, "R6 cycle count");
    bus_rd(32'h00, 32'h0, "R6 select reads zero");
    idle(5);
    bus_rd(32'h20, 32'd37, "R5 cycle count held");

    // R4 event counting on counter 1, other lanes ignored
    bus_wr(32'h04, 32'h0400_0006);
    mc_evt = 8'h01; idle(9);
    mc_evt = 8'h02; idle(4);
    mc_evt = 8'h00;
    bus_wr(32'h04, 32'h0400_0000);
    bus_rd(32'h24, 32'd9, "R4 event count");
    bus_rd(32'h04, 32'h0400_0000, "R3 ctrl1 fields");
    mc_evt = 8'h01; idle(6); mc_evt = 8'h00;
    bus_rd(32'h24, 32'd9, "R5 stopped count held");
    bus_wr(32'h24, 32'hDEAD_BEEF);
    bus_rd(32'h24, 32'd9, "R11 count write ignored");

    // R7 lane mapping on counter 2
    for (int j = 0; j < 8; j++) begin
      bus_wr(32'h08, {codes[j], 24'h000006});
      mc_evt = 8'(1 << j); idle(j + 1);
      mc_evt = ~8'(1 << j); idle(3);
      mc_evt = 8'h00;
      bus_wr(32'h08, {codes[j], 24'h0});
      bus_rd(32'h28, 32'(j + 1), $sformatf("R7 lane %0d", j));
    end
    bus_wr(32'h08, 32'h7700_0006);
    mc_evt = 8'hFF; rd_txn_vld = 1'b1; wr_txn_vld = 1'b1; idle(5);
    mc_evt = 8'h00; rd_txn_vld = 1'b0; wr_txn_vld = 1'b0;
    bus_wr(32'h08, 32'h7700_0000);
    bus_rd(32'h28, 32'h0, "R7 unmapped code counts nothing");

    // R8 ID filter on counter 3
    bus_wr(32'h30, 32'h00FF_0012);
    bus_rd(32'h30, 32'h00FF_0012, "R8 filter readback");
    bus_wr(32'h0C, 32'h4100_0006);
    rd_txn_vld = 1'b1; rd_txn_id = 16'h3412; idle(1);
    rd_txn_id = 16'h3413; idle(1);
    rd_txn_id = 16'hAB12; idle(1);
    rd_txn_vld = 1'b0; wr_txn_vld = 1'b1; wr_txn_id = 16'h0012; idle(1);
    wr_txn_vld = 1'b0;
    bus_wr(32'h0C, 32'h4100_0000);
    bus_rd(32'h2C, 32'd2, "R8 read ID filter");
    bus_wr(32'h0C, 32'h4200_0006);
    wr_txn_vld = 1'b1; wr_txn_id = 16'h5512; idle(1);
    wr_txn_id = 16'h0013; idle(1);
    wr_txn_vld = 1'b0; rd_txn_vld = 1'b1; rd_txn_id = 16'h0012; idle(1);
    rd_txn_vld = 1'b0;
    bus_wr(32'h0C, 32'h4200_0000);
    bus_rd(32'h2C, 32'd1, "R8 write ID filter");

    // R3 clear alone
    bus_wr(32'h04, 32'h0000_0002);
    bus_rd(32'h24, 32'h0, "R4 clear zeroes count");
    bus_rd(32'h04, 32'h0, "R3 clear reads zero");

    // R11 unmapped addresses
    bus_wr(32'h40, 32'hFFFF_FFFF);
    bus_rd(32'h40, 32'h0, "R11 read 0x40");
    bus_rd(32'h1C, 32'h0, "R11 read 0x1C");
    bus_rd(32'h34, 32'h0, "R11 read 0x34");

    // R10 event counter overflow leaves irq low
    bus_wr(32'h04, 32'h0500_0006);
    mc_evt = 8'h02; idle(1 << CW); mc_evt = 8'h00;
    chk("R10 event overflow no irq", {31'b0, irq}, 32'h0);
    bus_rd(32'h04, 32'h0500_0005, "R9 event overflow flag");
    bus_rd(32'h24, 32'h0, "R9 event count wrapped");

    // R9/R10 cycle counter overflow
    bus_wr(32'h00, 32'h6);
    idle((1 << CW) - 1);
    chk("R10 irq before wrap", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R10 irq at wrap", {31'b0, irq}, 32'h1);
    bus_rd(32'h00, 32'h5, "R9 cycle overflow flag");
    idle(4);
    bus_wr(32'h00, 32'h4);
    chk("R9 flag sticky without clear", {31'b0, irq}, 32'h1);
    bus_wr(32'h00, 32'h6);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);
    bus_rd(32'h00, 32'h4, "R9 flag cleared");
    bus_wr(32'h00, 32'h0);

    idle(3);
    chk("R2 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule